// File: doc/BRIEF.md
# Bit Counting Unit

This unit takes a 32-bit operand and a two-bit operation code and reports one of three counts: the number of zero bits above the highest set bit, the number of zero bits below the lowest set bit, or the number of set bits. The count is at most 32, so it fits in six bits. It is placed at the bottom of a 32-bit result word, and every bit above it is zero.

The leading-zero and trailing-zero counts share one priority encoder. For a trailing-zero count, the encoder sees the operand with its bits reversed. An operand with no bits set gives the full word width for both zero counts. The result is not left undefined in that case.

The operand is captured together with an input strobe. The result and an output strobe appear one clock later. The result register keeps its value until the next strobed operand.

Top module: `bit_count_unit`

## Requirements
- R1: With op code 2'b00, the result is the number of zero bits above the highest set bit, counting down from bit 31. For example, 0x80000000 gives 0 and 0x121f5000 gives 3.
- R2: With op code 2'b01, the result is the number of zero bits below the lowest set bit, counting up from bit 0. For example, 0x80000000 gives 31 and 0x121f5000 gives 12.
- R3: With op code 2'b10, the result is the number of set bits. For example, 0x7fffffff gives 31, 0xffff8000 gives 17 and 0x121f5000 gives 9.
- R4: An all-zero operand gives 32 for op code 2'b00, 32 for op code 2'b01 and 0 for op code 2'b10.
- R5: Op code 2'b11 gives a result of 0 for any operand.
- R6: The count sits in result bits [5:0]. Result bits [31:6] are always 0.
- R7: out_valid_o is high in the cycle after a cycle with in_valid_i high, and low in the cycle after a cycle with in_valid_i low.
- R8: A cycle with in_valid_i low leaves result_o unchanged, whatever the operand and op code inputs hold.
- R9: While rst_ni is low, out_valid_o and result_o are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Operand and op code are valid this cycle |
| operand_i | input | 32 | Value to be counted |
| op_sel_i | input | 2 | 00 leading zeros, 01 trailing zeros, 10 set bits, 11 zero |
| out_valid_o | output | 1 | result_o holds a new result |
| result_o | output | 32 | Count, zero-extended |

## Verification
Uniformly random operands almost never exercise the deep end of the shared priority encoder. Long runs of leading or trailing zeros hardly ever occur, and the all-zero word occurs practically never. The stimulus therefore takes random words, shifts them right or left by a random amount and sometimes masks them to a single bit. This spreads both zero counts across 0 to 32. A directed table adds the exact boundary words.

The hold requirement can only be seen at the ports. To check it, the bench changes the operand and op code while the strobe is low and then confirms that the result does not move.

// File: rtl/bcu_pkg.sv
package bcu_pkg;
  typedef enum logic [1:0] {
    OP_LEAD  = 2'b00,
    OP_TRAIL = 2'b01,
    OP_POP   = 2'b10,
    OP_NONE  = 2'b11
  } bcu_op_e;
endpackage

// File: rtl/bcu_lzc.sv
// Priority encoder: zeros above the highest set bit; all-zero gives WIDTH.
module bcu_lzc #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0]         vec_i,
  output logic [$clog2(WIDTH):0]   cnt_o
);
  localparam int CW = $clog2(WIDTH) + 1;

  always_comb begin
    cnt_o = CW'(WIDTH);
    for (int i = 0; i < WIDTH; i++) begin
      if (vec_i[i]) cnt_o = CW'(WIDTH - 1 - i);
    end
  end

  always_comb begin
    p_cnt_range_r4: assert (cnt_o <= CW'(WIDTH));
  end
endmodule

// File: rtl/bcu_popcnt.sv
module bcu_popcnt #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0]         vec_i,
  output logic [$clog2(WIDTH):0]   cnt_o
);
  localparam int CW = $clog2(WIDTH) + 1;

  always_comb begin
    cnt_o = '0;
    for (int i = 0; i < WIDTH; i++) begin
      cnt_o = cnt_o + CW'(vec_i[i]);
    end
  end

  always_comb begin
    p_full_count_r3: assert (!(&vec_i) || cnt_o == CW'(WIDTH));
  end
endmodule

// File: rtl/bit_count_unit.sv
module bit_count_unit
  import bcu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             in_valid_i,
  input  logic [31:0]      operand_i,
  input  logic [1:0]       op_sel_i,
  output logic             out_valid_o,
  output logic [31:0]      result_o
);
  localparam int CW = $clog2(WIDTH) + 1;

  bcu_op_e          op;
  logic [WIDTH-1:0] opnd;
  logic [WIDTH-1:0] opnd_rev;
  logic [WIDTH-1:0] scan_vec;
  logic [CW-1:0]    zcnt;
  logic [CW-1:0]    pcnt;
  logic [31:0]      res_d;
  logic [31:0]      res_q;
  logic             vld_q;

  assign op   = bcu_op_e'(op_sel_i);
  assign opnd = operand_i[WIDTH-1:0];

  for (genvar g = 0; g < WIDTH; g++) begin : g_rev
    assign opnd_rev[g] = opnd[WIDTH-1-g];
  end

  // trailing count reuses the leading-zero encoder on the reversed word
  assign scan_vec = (op == OP_TRAIL) ? opnd_rev : opnd;

  bcu_lzc #(.WIDTH(WIDTH)) u_lzc (
    .vec_i (scan_vec),
    .cnt_o (zcnt)
  );

  bcu_popcnt #(.WIDTH(WIDTH)) u_pop (
    .vec_i (opnd),
    .cnt_o (pcnt)
  );

  always_comb begin
    res_d = '0;
    unique case (op)
      OP_LEAD, OP_TRAIL: res_d[CW-1:0] = zcnt;
      OP_POP:            res_d[CW-1:0] = pcnt;
      default:           res_d = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= 1'b0;
      res_q <= '0;
    end else begin
      vld_q <= in_valid_i;
      if (in_valid_i) res_q <= res_d;
    end
  end

  assign out_valid_o = vld_q;
  assign result_o    = res_q;

  p_valid_rise_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i |=> out_valid_o);
  p_valid_fall_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |=> !out_valid_o);
  p_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |=> $stable(result_o));
  p_upper_zero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    result_o[31:6] == '0);
  p_none_zero_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && op_sel_i == 2'b11) |=> result_o == '0);
  p_zero_width_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && operand_i == '0 && !op_sel_i[1]) |=> result_o == 32'(WIDTH));
endmodule

// File: tb/bit_count_unit_bench.sv
module bit_count_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] operand = '0;
  logic [1:0]  op_sel = '0;
  logic        out_valid;
  logic [31:0] result;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  bit_count_unit u_bit_count_unit (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .in_valid_i  (in_valid),
    .operand_i   (operand),
    .op_sel_i    (op_sel),
    .out_valid_o (out_valid),
    .result_o    (result)
  );

  // {operand, leading, trailing, popcount}
  localparam int NV = 9;
  localparam logic [55:0] VEC [NV] = '{
    {32'h0000_0000, 8'd32, 8'd32, 8'd0},
    {32'h0000_0001, 8'd31, 8'd0,  8'd1},
    {32'h8000_0000, 8'd0,  8'd31, 8'd1},
    {32'h7fff_ffff, 8'd1,  8'd0,  8'd31},
    {32'hffff_8000, 8'd0,  8'd15, 8'd17},
    {32'h121f_5000, 8'd3,  8'd12, 8'd9},
    {32'h0000_7fff, 8'd17, 8'd0,  8'd15},
    {32'h0000_000e, 8'd28, 8'd1,  8'd3},
    {32'hffff_ffff, 8'd0,  8'd0,  8'd32}
  };

  function automatic int m_lead(input logic [31:0] v);
    int n = 0;
    for (int i = 31; i >= 0; i--) begin
      if (v[i]) return n;
      n++;
    end
    return n;
  endfunction

  function automatic int m_trail(input logic [31:0] v);
    int n = 0;
    for (int i = 0; i < 32; i++) begin
      if (v[i]) return n;
      n++;
    end
    return n;
  endfunction

  function automatic int m_pop(input logic [31:0] v);
    int n = 0;
    for (int i = 0; i < 32; i++) n += int'(v[i]);
    return n;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [31:0] v, input logic [1:0] sel);
    @(negedge clk);
    in_valid = 1'b1;
    operand  = v;
    op_sel   = sel;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic run_one(input logic [31:0] v, input logic [1:0] sel,
                         input int exp, input string req);
    issue(v, sel);
    check({req, " valid"}, 32'(out_valid), 32'd1);
    check(req, result, 32'(exp));
    check("R6 upper", {26'd0, 6'(result[31:6] != '0)}, 32'd0);
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] held;
    #23;
    check("R9 reset valid", 32'(out_valid), 32'd0);
    check("R9 reset result", result, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;

    for (int k = 0; k < NV; k++) begin
      run_one(VEC[k][55:24], 2'b00, int'(VEC[k][23:16]), "R1 lead");
      run_one(VEC[k][55:24], 2'b01, int'(VEC[k][15:8]),  "R2 trail");
      run_one(VEC[k][55:24], 2'b10, int'(VEC[k][7:0]),   "R3 pop");
    end

    run_one(32'h0, 2'b00, 32, "R4 zero lead");
    run_one(32'h0, 2'b01, 32, "R4 zero trail");
    run_one(32'h0, 2'b10, 0,  "R4 zero pop");
    run_one(32'hffff_ffff, 2'b11, 0, "R5 none");
    run_one(32'h121f_5000, 2'b11, 0, "R5 none");

    // R7/R8: idle strobe, changing inputs must not disturb the result
    run_one(32'h0000_0100, 2'b01, 8, "R2 trail");
    held = result;
    @(negedge clk);
    operand = 32'h0;
    op_sel  = 2'b00;
    @(negedge clk);
    check("R7 idle valid", 32'(out_valid), 32'd0);
    check("R8 hold", result, held);
    @(negedge clk);
    check("R8 hold", result, held);

    // R7: back-to-back strobes
    @(negedge clk);
    in_valid = 1'b1; operand = 32'h0000_0010; op_sel = 2'b01;
    @(negedge clk);
    check("R7 b2b valid", 32'(out_valid), 32'd1);
    check("R2 b2b", result, 32'd4);
    operand = 32'h0000_0010; op_sel = 2'b00;
    @(negedge clk);
    in_valid = 1'b0;
    check("R7 b2b valid", 32'(out_valid), 32'd1);
    check("R1 b2b", result, 32'd27);

    for (int k = 0; k < 300; k++) begin
      logic [31:0] v;
      logic [1:0]  sel;
      int          e;
      v = $urandom();
      case (k % 4)
        0: v = v >> ($urandom() % 33);
        1: v = v << ($urandom() % 33);
        2: v = 32'h1 << ($urandom() % 32);
        default: ;
      endcase
      if (k % 37 == 0) v = '0;
      sel = 2'($urandom() % 4);
      case (sel)
        2'b00:   e = m_lead(v);
        2'b01:   e = m_trail(v);
        2'b10:   e = m_pop(v);
        default: e = 0;
      endcase
      run_one(v, sel, e, sel == 2'b00 ? "R1 rand" : sel == 2'b01 ? "R2 rand" :
                         sel == 2'b10 ? "R3 rand" : "R5 rand");
    end

    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R9 reset valid", 32'(out_valid), 32'd0);
    check("R9 reset result", result, 32'd0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule